// File: doc/BRIEF.md
# NAND Flash Register Bridge

This block lets a host drive a raw 8-bit NAND flash bus through a single 32-bit register. Each host write packs a chip-enable flag, an operation code and one data byte. The block turns that write into one timed bus cycle: it raises the command or address latch line as the operation requires, drives the byte onto the flash data lines and pulses the write strobe low once. Operation code 2 arms reading. The arming write takes no byte. Instead it runs one read-strobe cycle at once, so the first byte is already captured when the host first reads the register.

Each host read returns the latched chip-enable, the most recently captured flash byte and a busy flag. While reading is armed, every register read also starts one more read-strobe cycle, so the byte for the next read is fetched in advance. Writing a command, an address or data ends the armed state. The busy flag is set while a bus cycle is in progress. It is also set while the flash ready/busy pin, after a two-flop synchronizer, shows the device as busy. All strobe phases last a parameterised number of clock cycles.

Top module: `nand_reg_bridge`

## Requirements
- R1: After reset, chip enable is deasserted (high), both latch lines are low, both strobes are high, the data lines are released, and the register read value is all zero while the ready/busy pin is high.
- R2: A write with bits 30:28 = 0 (command) runs one cycle in which the command latch line is high and the address latch line is low for the whole cycle, and the data lines carry write bits 23:16.
- R3: A write with bits 30:28 = 1 (address) runs one cycle in which the address latch line is high and the command latch line is low for the whole cycle.
- R4: A write with bits 30:28 = 3 (data) runs one cycle in which both latch lines stay low while the write strobe pulses once with write bits 23:16 on the data lines.
- R5: On every accepted write with operation 0 to 3, chip enable takes write bit 31 from the next clock (bit 31 = 1 drives it low). Chip enable holds its value at all other times.
- R6: Every bus cycle lasts 3·PULSE_CYC clocks: PULSE_CYC clocks of setup with the strobes high, PULSE_CYC clocks with the strobe low, and PULSE_CYC clocks of hold with the strobe high. The latch lines and data lines are stable through all three phases.
- R7: A write with operation 2 arms reading and runs one read-strobe cycle with no write strobe. The byte on the flash data lines in the last low clock of that strobe is captured.
- R8: The register read value carries the captured byte in bits 23:16 and chip enable in bit 31. A register read made while reading is armed starts one more read-strobe cycle.
- R9: A register read made while reading is not armed returns the last captured byte and produces no read strobe.
- R10: Writes with operation 4 to 7 produce no bus activity and leave chip enable and the armed state unchanged.
- R11: Bit 15 of the read value is 1 while a bus cycle is in progress, or while the ready/busy pin was low two clocks earlier.
- R12: Host writes and reads that arrive while a bus cycle is in progress are ignored.
- R13: An accepted write with operation 0, 1 or 3 ends the armed state.
- R14: The data lines are driven only during write-type cycles (operations 0, 1 and 3) and are released at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_wr | input | 1 | One-clock register write request |
| host_wdata | input | 32 | Register write value |
| host_rd | input | 1 | One-clock register read request |
| host_rdata | output | 32 | Register read value |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_cle | output | 1 | Flash command latch enable |
| fl_ale | output | 1 | Flash address latch enable |
| fl_we_n | output | 1 | Flash write strobe, active low |
| fl_re_n | output | 1 | Flash read strobe, active low |
| fl_dq_o | output | 8 | Flash data lines, outgoing value |
| fl_dq_oe | output | 1 | Flash data line drive enable |
| fl_dq_i | input | 8 | Flash data lines, incoming value |
| fl_rb_n | input | 1 | Flash ready/busy, low while busy |

## Verification
The sequence writes a command, an address and data, with chip enable both set and cleared. Each write is checked for its latch-line pattern, its strobe phases and its data byte. This separates a wrong operation decode from a wrong phase length. Reading is tried with an arming write followed by several reads while the bench changes the flash data lines on every clock, so a byte sampled one clock early or late is caught. The remaining accesses are reads after disarming, reserved operation codes, accesses made during a running cycle, and a low pulse on the ready/busy pin. These show whether an ignored access is really ignored and whether busy follows the synchronized pin.

// File: rtl/nrb_pkg.sv
package nrb_pkg;
   // register field positions decoded by host software
   localparam int CE_BIT   = 31;
   localparam int OP_HI    = 30;
   localparam int OP_LO    = 28;
   localparam int BYTE_LO  = 16;
   localparam int BYTE_W   = 8;
   localparam int BUSY_BIT = 15;

   typedef enum logic [1:0] {K_CMD = 2'd0, K_ADDR = 2'd1, K_READ = 2'd2, K_DATA = 2'd3} cyc_kind_t;
   typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_LOW, PH_HOLD} phase_t;
endpackage

// File: rtl/nrb_sync.sv
module nrb_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("nrb_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/nrb_decode.sv
module nrb_decode
   import nrb_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic [31:0]       host_wdata,
   input  logic              host_rd,
   input  logic              cyc_busy,
   output logic              start,
   output cyc_kind_t         kind,
   output logic [BYTE_W-1:0] wbyte,
   output logic              ce_q
);
   logic [2:0] op;
   logic       op_ok;
   logic       armed;

   assign op    = host_wdata[OP_HI:OP_LO];
   assign op_ok = host_wr && !op[2];
   assign wbyte = host_wdata[BYTE_LO +: BYTE_W];

   always_comb begin
      start = 1'b0;
      kind  = K_CMD;
      if (!cyc_busy) begin
         if (op_ok) begin
            start = 1'b1;
            kind  = cyc_kind_t'(op[1:0]);
         end else if (host_rd && !host_wr && armed) begin
            start = 1'b1;
            kind  = K_READ;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ce_q  <= 1'b0;
         armed <= 1'b0;
      end else if (!cyc_busy && op_ok) begin
         ce_q  <= host_wdata[CE_BIT];
         armed <= (op[1:0] == 2'd2);
      end
   end

   // R10: a reserved code never starts a cycle on its own
   assert_reserved_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && op[2] && !host_rd) |-> !start);
endmodule

// File: rtl/nrb_strobe.sv
module nrb_strobe
   import nrb_pkg::*;
#(
   parameter int PULSE_CYC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  cyc_kind_t         kind,
   input  logic [BYTE_W-1:0] wbyte,
   input  logic [BYTE_W-1:0] dq_i,
   output logic              we_n,
   output logic              re_n,
   output logic              cle,
   output logic              ale,
   output logic [BYTE_W-1:0] dq_o,
   output logic              dq_oe,
   output logic [BYTE_W-1:0] cap,
   output logic              busy
);
   localparam int CW = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;

   if (PULSE_CYC < 1) begin : g_bad_pulse
      $error("nrb_strobe: PULSE_CYC must be at least 1");
   end

   phase_t            phase;
   cyc_kind_t         kind_q;
   logic [BYTE_W-1:0] byte_q;
   logic              cnt_last;
   logic              active;
   logic              wr_kind;

   if (PULSE_CYC == 1) begin : g_nocnt
      assign cnt_last = 1'b1;
   end else begin : g_cnt
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                           cnt <= '0;
         else if (phase == PH_IDLE || cnt_last) cnt <= '0;
         else                                  cnt <= cnt + 1'b1;
      end
      assign cnt_last = (cnt == CW'(PULSE_CYC - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= PH_IDLE;
         kind_q <= K_CMD;
         byte_q <= '0;
         cap    <= '0;
      end else begin
         unique case (phase)
            PH_IDLE: if (start) begin
               phase  <= PH_SETUP;
               kind_q <= kind;
               byte_q <= wbyte;
            end
            PH_SETUP: if (cnt_last) phase <= PH_LOW;
            PH_LOW: if (cnt_last) begin
               phase <= PH_HOLD;
               if (kind_q == K_READ) cap <= dq_i;
            end
            PH_HOLD: if (cnt_last) phase <= PH_IDLE;
            default: phase <= PH_IDLE;
         endcase
      end
   end

   assign active  = (phase != PH_IDLE);
   assign wr_kind = (kind_q != K_READ);
   assign we_n    = !(phase == PH_LOW && wr_kind);
   assign re_n    = !(phase == PH_LOW && !wr_kind);
   assign cle     = active && (kind_q == K_CMD);
   assign ale     = active && (kind_q == K_ADDR);
   assign dq_oe   = active && wr_kind;
   assign dq_o    = byte_q;
   assign busy    = active;

   assert_one_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(!we_n && !re_n));
   assert_latch_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(cle && ale));
   assert_bus_released_R14: assert property (@(posedge clk) disable iff (!rst_n)
      !re_n |-> !dq_oe);
   assert_setup_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(we_n) |-> ($stable(cle) && $stable(ale) && $stable(dq_o) && dq_oe));
   assert_hold_driven_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(we_n) |-> dq_oe);
endmodule

// File: rtl/nand_reg_bridge.sv
module nand_reg_bridge
   import nrb_pkg::*;
#(
   parameter int PULSE_CYC   = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        host_wr,
   input  logic [31:0] host_wdata,
   input  logic        host_rd,
   output logic [31:0] host_rdata,
   output logic        fl_ce_n,
   output logic        fl_cle,
   output logic        fl_ale,
   output logic        fl_we_n,
   output logic        fl_re_n,
   output logic [7:0]  fl_dq_o,
   output logic        fl_dq_oe,
   input  logic [7:0]  fl_dq_i,
   input  logic        fl_rb_n
);
   logic              start;
   cyc_kind_t         kind;
   logic [BYTE_W-1:0] wbyte;
   logic              ce_q;
   logic              cyc_busy;
   logic [BYTE_W-1:0] cap;
   logic              rb_sync;
   logic              unused_bits;

   assign unused_bits = ^{host_wdata[27:24], host_wdata[15:0]};

   nrb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(fl_rb_n), .q(rb_sync));

   nrb_decode u_dec (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
      .host_rd(host_rd), .cyc_busy(cyc_busy), .start(start), .kind(kind),
      .wbyte(wbyte), .ce_q(ce_q));

   nrb_strobe #(.PULSE_CYC(PULSE_CYC)) u_stb (
      .clk(clk), .rst_n(rst_n), .start(start), .kind(kind), .wbyte(wbyte),
      .dq_i(fl_dq_i), .we_n(fl_we_n), .re_n(fl_re_n), .cle(fl_cle), .ale(fl_ale),
      .dq_o(fl_dq_o), .dq_oe(fl_dq_oe), .cap(cap), .busy(cyc_busy));

   assign fl_ce_n = !ce_q;

   always_comb begin
      host_rdata                        = '0;
      host_rdata[CE_BIT]                = ce_q;
      host_rdata[BYTE_LO +: BYTE_W]     = cap;
      host_rdata[BUSY_BIT]              = cyc_busy || !rb_sync;
   end

   assert_ce_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !host_wr |=> $stable(fl_ce_n));
   assert_busy_ignore_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_busy && host_wr) |=> $stable(fl_ce_n));
   assert_busy_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!fl_we_n || !fl_re_n) |-> host_rdata[BUSY_BIT]);
endmodule

// File: tb/nand_reg_bridge_test.sv
module nand_reg_bridge_test;
   localparam int CLK_PERIOD = 10;
   localparam int P = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr = 1'b0;
   logic [31:0] host_wdata = '0;
   logic        host_rd = 1'b0;
   logic [31:0] host_rdata;
   logic        fl_ce_n, fl_cle, fl_ale, fl_we_n, fl_re_n, fl_dq_oe;
   logic [7:0]  fl_dq_o;
   logic [7:0]  fl_dq_i = 8'h00;
   logic        fl_rb_n = 1'b1;

   int total = 0;
   int bad = 0;
   bit done = 0;
   int we_falls = 0;
   int re_falls = 0;
   int tick = 0;

   // behavioural reference state
   bit       m_act, m_ce, m_armed;
   int       m_el, m_kind;
   bit [7:0] m_byte, m_cap;
   bit       rbq[$];

   nand_reg_bridge #(.PULSE_CYC(P), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
      .host_rd(host_rd), .host_rdata(host_rdata), .fl_ce_n(fl_ce_n),
      .fl_cle(fl_cle), .fl_ale(fl_ale), .fl_we_n(fl_we_n), .fl_re_n(fl_re_n),
      .fl_dq_o(fl_dq_o), .fl_dq_oe(fl_dq_oe), .fl_dq_i(fl_dq_i), .fl_rb_n(fl_rb_n));

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic void chk(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h (t=%0t)", req, act, exp, $time);
      end
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_act = 0; m_ce = 0; m_armed = 0; m_el = 0; m_kind = 0;
         m_byte = 0; m_cap = 0;
         rbq = '{1'b1, 1'b1};
      end else begin
         rbq.push_back(fl_rb_n);
         void'(rbq.pop_front());
         if (m_act) begin
            if (m_kind == 2 && m_el == 2*P-1) m_cap = fl_dq_i;
            if (m_el == 3*P-1) m_act = 0;
            else m_el++;
         end else if (host_wr && !host_wdata[30]) begin
            m_ce = host_wdata[31];
            m_kind = int'(host_wdata[29:28]);
            m_byte = host_wdata[23:16];
            m_armed = (m_kind == 2);
            m_act = 1; m_el = 0;
         end else if (host_rd && !host_wr && m_armed) begin
            m_act = 1; m_el = 0; m_kind = 2;
         end
      end
   end

   // flash side stimulus, strobe edge counters, per-clock comparison
   always @(negedge clk) begin
      tick++;
      fl_dq_i <= 8'(tick * 37) ^ 8'h5A;
      if (rst_n) begin
         bit low, wrk;
         logic [31:0] er;
         low = m_act && m_el >= P && m_el < 2*P;
         wrk = m_kind != 2;
         chk("R6 we_n", fl_we_n, !(low && wrk));
         chk("R7 re_n", fl_re_n, !(low && !wrk));
         chk("R2 cle", fl_cle, m_act && m_kind == 0);
         chk("R3 ale", fl_ale, m_act && m_kind == 1);
         chk("R14 dq_oe", fl_dq_oe, m_act && wrk);
         if (m_act && wrk) chk("R2 dq_o", fl_dq_o, m_byte);
         chk("R5 ce_n", fl_ce_n, !m_ce);
         er = '0;
         er[31] = m_ce;
         er[23:16] = m_cap;
         er[15] = m_act || !rbq[0];
         chk("R8 rdata byte", host_rdata[31:16], er[31:16]);
         chk("R11 busy", host_rdata[15], er[15]);
      end
   end

   always @(negedge fl_we_n) we_falls++;
   always @(negedge fl_re_n) re_falls++;

   task automatic hw(input logic [31:0] v);
      @(negedge clk); host_wr = 1; host_wdata = v;
      @(negedge clk); host_wr = 0; host_wdata = '0;
   endtask

   task automatic hr(output logic [31:0] v);
      @(negedge clk); host_rd = 1; v = host_rdata;
      @(negedge clk); host_rd = 0;
   endtask

   task automatic settle();
      while (m_act) @(negedge clk);
      @(negedge clk);
   endtask

   function automatic logic [31:0] pack(bit ce, int op, logic [7:0] b);
      logic [31:0] v = '0;
      v[31] = ce; v[30:28] = 3'(op); v[23:16] = b;
      return v;
   endfunction

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog act=running exp=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] rv;
      int w0, r0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 ce_n", fl_ce_n, 1); chk("R1 we_n", fl_we_n, 1); chk("R1 re_n", fl_re_n, 1);
      chk("R1 cle/ale", {fl_cle, fl_ale}, 0); chk("R1 oe", fl_dq_oe, 0);
      chk("R1 rdata", host_rdata, 0);
      rst_n = 1;
      repeat (3) @(negedge clk);
      chk("R1 rdata after release", host_rdata, 0);

      hw(pack(1, 0, 8'h70)); settle();
      hw(pack(1, 1, 8'h12)); settle();
      // R4: data cycle, both latch lines low in the strobe
      w0 = we_falls;
      hw(pack(1, 3, 8'hA5));
      repeat (P) @(negedge clk);
      chk("R4 latch lines", {fl_cle, fl_ale, fl_we_n}, 3'b000);
      settle();
      chk("R4 one strobe", we_falls - w0, 1);

      // R7/R8 arm then drain
      r0 = re_falls;
      hw(pack(1, 2, 8'hFF)); settle();
      chk("R7 arm strobe", re_falls - r0, 1);
      for (int i = 0; i < 3; i++) begin hr(rv); settle(); end
      chk("R8 read strobes", re_falls - r0, 4);

      // R13 then R9: data write disarms, read makes no strobe
      hw(pack(1, 3, 8'h3C)); settle();
      r0 = re_falls;
      hr(rv); repeat (3*P + 2) @(negedge clk);
      chk("R9 no strobe", re_falls - r0, 0);
      chk("R13 disarmed", fl_re_n, 1);

      // R10 reserved codes
      w0 = we_falls;
      for (int op = 4; op < 8; op++) begin hw(pack(0, op, 8'h99)); settle(); end
      chk("R10 no bus", we_falls - w0, 0);
      chk("R10 ce kept", fl_ce_n, 0);

      // R12 write during a running cycle
      w0 = we_falls;
      hw(pack(1, 0, 8'h90));
      hw(pack(0, 1, 8'h55));
      settle();
      chk("R12 ignored", we_falls - w0, 1);
      chk("R12 ce kept", fl_ce_n, 0);

      // R11 ready/busy pin
      @(negedge clk); fl_rb_n = 0;
      repeat (6) @(negedge clk);
      chk("R11 pin busy", host_rdata[15], 1);
      fl_rb_n = 1;
      repeat (4) @(negedge clk);
      chk("R11 pin ready", host_rdata[15], 0);

      // R5 chip enable released with another reading pass
      hw(pack(0, 3, 8'h01)); settle();
      chk("R5 ce off", fl_ce_n, 1);
      hw(pack(0, 2, 8'h00)); settle();
      hr(rv); settle();
      hr(rv); settle();

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule